// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small chip between a running state and two reduced-power states, idle and sleep. Software asks for a state with a one-cycle request. A general interrupt line and a bank of wake-capable lines, which work without a clock, bring the chip back. The block registers every clock and power enable it drives: the CPU/memory/bus clock, the peripheral clocks, the main oscillator, the internal RC oscillator output and the flash supply. It also owns the PLL enable, the PLL connect select and a strobe that clears the clock dividers.

The two low-power states work differently. Idle removes only the CPU-side clock and ends on any interrupt. Sleep does more. It stops the main oscillator and all internal clocks, and it gates the RC oscillator output while that oscillator stays powered. It forces the PLL off and disconnected and pulses the divider clear. Only a wake-capable line ends sleep. After sleep, and after reset, the oscillator restarts and a wake-up counter must count a set number of oscillator ticks before the CPU clock returns. Once the counter has finished, the PLL stays off until software writes it again. A clear-on-read code records which mode the chip last left.

Top module: `pwr_mode_seq`

## Requirements
- R1: While and after reset: cpu_clk_en=0, per_clk_en=0, osc_en=1, irc_out_en=1, flash_en=1, pll_en=0, pll_conn=0, div_rst=0, exit_code=0.
- R2: While the oscillator warms up, cpu_clk_en stays 0 until WAKE_CYCLES cycles with osc_tick=1 have been counted. cpu_clk_en rises on the second clock edge after the cycle that carries the last counted tick, and per_clk_en rises with it.
- R3: In idle: cpu_clk_en=0, per_clk_en=1, osc_en=1, irc_out_en=1.
- R4: Idle ends when irq_any or any wake_irq bit is high at a clock edge. After that edge cpu_clk_en=1, with no warm-up count.
- R5: In sleep: osc_en=0, cpu_clk_en=0, per_clk_en=0, irc_out_en=0, and flash_en stays 1.
- R6: On the edge that enters sleep, pll_en and pll_conn go to 0, and div_rst is 1 for exactly one cycle.
- R7: In sleep, irq_any has no effect. Sleep ends only when a wake_irq bit is high, and it then goes to warm-up (osc_en=1, cpu_clk_en=0) with the tick count started again from zero.
- R8: req_idle and req_sleep take effect only in the running state. If both are high, sleep wins.
- R9: cfg_wr loads pll_en=cfg_pll_en and pll_conn=cfg_pll_conn&cfg_pll_en, but only in the running state. Outside that state cfg_wr is ignored, so the PLL stays off after a sleep wake-up until software writes it.
- R10: exit_code becomes 1 when idle ends and 2 when sleep ends. It becomes 0 after a cycle with stat_rd=1, unless a new exit happens in that same cycle; the new exit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per synchronized oscillator edge |
| req_idle | input | 1 | Software request to enter idle |
| req_sleep | input | 1 | Software request to enter sleep |
| irq_any | input | 1 | Any enabled interrupt |
| wake_irq | input | N_WAKE | Wake-capable interrupts that need no clock |
| cfg_wr | input | 1 | Software write of the PLL controls |
| cfg_pll_en | input | 1 | PLL enable value to write |
| cfg_pll_conn | input | 1 | PLL connect value to write |
| stat_rd | input | 1 | Read of the exit code, which clears it |
| cpu_clk_en | output | 1 | CPU, memory and bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| irc_out_en | output | 1 | RC oscillator output gate |
| flash_en | output | 1 | Flash power enable |
| pll_en | output | 1 | PLL power enable |
| pll_conn | output | 1 | PLL connect select |
| div_rst | output | 1 | One-cycle clock-divider clear |
| exit_code | output | 2 | Last exited mode: 0 none, 1 idle, 2 sleep |

## Verification
Some rules hold in every cycle, and the assertions check those: the enable pattern in idle and in sleep, the PLL being off in sleep, the one-cycle width of the divider clear, sleep holding while no wake line is high, sleep winning over idle, the connect select needing the enable, and the CPU clock staying off while the count is unfinished. Other behaviour only the bench scenarios can show. These cover the exact edge on which the CPU clock returns after a given number of ticks, the count starting again after a sleep wake-up, PLL writes being ignored outside the running state, and the exit code being set, read and cleared, including when a read and an exit fall in the same cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    ST_WARM  = 2'd0,
    ST_RUN   = 2'd1,
    ST_IDLE  = 2'd2,
    ST_SLEEP = 2'd3
  } pwr_state_e;

  localparam logic [1:0] EXIT_NONE  = 2'd0;
  localparam logic [1:0] EXIT_IDLE  = 2'd1;
  localparam logic [1:0] EXIT_SLEEP = 2'd2;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic irc;
    logic flash;
  } clk_ctl_t;

  function automatic clk_ctl_t state_enables(pwr_state_e s);
    clk_ctl_t c;
    c = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, irc: 1'b1, flash: 1'b1};
    case (s)
      ST_RUN:   begin c.cpu = 1'b1; c.per = 1'b1; end
      ST_IDLE:  begin c.per = 1'b1; end
      ST_SLEEP: begin c.osc = 1'b0; c.irc = 1'b0; end
      default:  ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 4096,
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic count_en,
  input  logic tick,
  output logic done
);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == CW'(WAKE_CYCLES));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (count_en && tick && !done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwr_pll_ctl.sv
module pwr_pll_ctl (
  input  logic clk,
  input  logic rst,
  input  logic force_off,
  input  logic cfg_ok,
  input  logic cfg_en,
  input  logic cfg_conn,
  output logic pll_en,
  output logic pll_conn,
  output logic div_rst
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en   <= 1'b0;
      pll_conn <= 1'b0;
      div_rst  <= 1'b0;
    end else begin
      div_rst <= force_off;
      if (force_off) begin
        pll_en   <= 1'b0;
        pll_conn <= 1'b0;
      end else if (cfg_ok) begin
        pll_en   <= cfg_en;
        pll_conn <= cfg_conn & cfg_en;
      end
    end
  end

endmodule

// File: rtl/pwr_exit_status.sv
module pwr_exit_status
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       left_idle,
  input  logic       left_sleep,
  input  logic       rd,
  output logic [1:0] code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= EXIT_NONE;
    end else if (left_sleep) begin
      code <= EXIT_SLEEP;
    end else if (left_idle) begin
      code <= EXIT_IDLE;
    end else if (rd) begin
      code <= EXIT_NONE;
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_WAKE      = 4,
  parameter int unsigned WAKE_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              req_idle,
  input  logic              req_sleep,
  input  logic              irq_any,
  input  logic [N_WAKE-1:0] wake_irq,
  input  logic              cfg_wr,
  input  logic              cfg_pll_en,
  input  logic              cfg_pll_conn,
  input  logic              stat_rd,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              irc_out_en,
  output logic              flash_en,
  output logic              pll_en,
  output logic              pll_conn,
  output logic              div_rst,
  output logic [1:0]        exit_code
);

  pwr_state_e state_q, state_d;
  clk_ctl_t   ena_q, ena_d;
  logic       timer_done;
  logic       wake_any;
  logic       enter_sleep;
  logic       left_idle;
  logic       left_sleep;

  assign wake_any = |wake_irq;

  always_comb begin
    state_d     = state_q;
    enter_sleep = 1'b0;
    left_idle   = 1'b0;
    left_sleep  = 1'b0;
    case (state_q)
      ST_WARM: begin
        if (timer_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (req_sleep) begin
          state_d     = ST_SLEEP;
          enter_sleep = 1'b1;
        end else if (req_idle) begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (irq_any || wake_any) begin
          state_d   = ST_RUN;
          left_idle = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_any) begin
          state_d    = ST_WARM;
          left_sleep = 1'b1;
        end
      end
      default: state_d = ST_WARM;
    endcase
  end

  assign ena_d = state_enables(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WARM;
      ena_q   <= state_enables(ST_WARM);
    end else begin
      state_q <= state_d;
      ena_q   <= ena_d;
    end
  end

  assign cpu_clk_en = ena_q.cpu;
  assign per_clk_en = ena_q.per;
  assign osc_en     = ena_q.osc;
  assign irc_out_en = ena_q.irc;
  assign flash_en   = ena_q.flash;

  pwr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (enter_sleep),
    .count_en (state_q == ST_WARM),
    .tick     (osc_tick),
    .done     (timer_done)
  );

  pwr_pll_ctl u_pll (
    .clk       (clk),
    .rst       (rst),
    .force_off (enter_sleep),
    .cfg_ok    (cfg_wr && (state_q == ST_RUN)),
    .cfg_en    (cfg_pll_en),
    .cfg_conn  (cfg_pll_conn),
    .pll_en    (pll_en),
    .pll_conn  (pll_conn),
    .div_rst   (div_rst)
  );

  pwr_exit_status u_status (
    .clk        (clk),
    .rst        (rst),
    .left_idle  (left_idle),
    .left_sleep (left_sleep),
    .rd         (stat_rd),
    .code       (exit_code)
  );

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_WAKE = 4
) (
  input logic              clk,
  input logic              rst,
  input pwr_state_e        state_q,
  input logic              timer_done,
  input logic              req_sleep,
  input logic [N_WAKE-1:0] wake_irq,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              osc_en,
  input logic              irc_out_en,
  input logic              flash_en,
  input logic              pll_en,
  input logic              pll_conn,
  input logic              div_rst
);

  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_IDLE |-> !cpu_clk_en && per_clk_en && osc_en && irc_out_en); // R3

  AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SLEEP |-> !osc_en && !cpu_clk_en && !per_clk_en && !irc_out_en && flash_en); // R5

  AST_SLEEP_PLL_OFF: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SLEEP |-> !pll_en && !pll_conn); // R6

  AST_DIV_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    div_rst |=> !div_rst); // R6

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && wake_irq == '0) |=> state_q == ST_SLEEP); // R7

  AST_SLEEP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && req_sleep) |=> state_q == ST_SLEEP); // R8

  AST_CONN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    pll_conn |-> pll_en); // R9

  AST_NO_EARLY_CPU: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM && !timer_done) |=> !cpu_clk_en); // R2

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_WAKE(N_WAKE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .state_q    (state_q),
  .timer_done (timer_done),
  .req_sleep  (req_sleep),
  .wake_irq   (wake_irq),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en),
  .irc_out_en (irc_out_en),
  .flash_en   (flash_en),
  .pll_en     (pll_en),
  .pll_conn   (pll_conn),
  .div_rst    (div_rst)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;

  localparam int NW  = 4;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 0, req_idle = 0, req_sleep = 0, irq_any = 0;
  logic [NW-1:0] wake_irq = '0;
  logic cfg_wr = 0, cfg_pll_en = 0, cfg_pll_conn = 0, stat_rd = 0;
  logic cpu_clk_en, per_clk_en, osc_en, irc_out_en, flash_en;
  logic pll_en, pll_conn, div_rst;
  logic [1:0] exit_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.N_WAKE(NW), .WAKE_CYCLES(LIM)) dut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .req_idle(req_idle),
    .req_sleep(req_sleep), .irq_any(irq_any), .wake_irq(wake_irq),
    .cfg_wr(cfg_wr), .cfg_pll_en(cfg_pll_en), .cfg_pll_conn(cfg_pll_conn),
    .stat_rd(stat_rd), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .irc_out_en(irc_out_en), .flash_en(flash_en),
    .pll_en(pll_en), .pll_conn(pll_conn), .div_rst(div_rst),
    .exit_code(exit_code)
  );

  // Entry bits: [6] req_idle [5] req_sleep [4] irq_any [3] wake_irq[0]
  //             [2] exp cpu_clk_en [1] exp per_clk_en [0] exp osc_en
  localparam int NV = 8;
  localparam logic [6:0] VEC [NV] = '{
    7'b1000_011,  // R3 enter idle
    7'b0000_011,  // R3 stay idle
    7'b0010_111,  // R4 irq ends idle
    7'b1100_000,  // R8 both requests: sleep wins; R5
    7'b0010_000,  // R7 irq_any ignored in sleep
    7'b1000_000,  // R8 request ignored in sleep
    7'b0001_001,  // R7 wake line -> warm-up
    7'b0000_001   // R7 still warming, no ticks
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    osc_tick = 1'b1;
    for (int k = 0; k < n; k++) cyc();
    osc_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 cpu", cpu_clk_en, 0); chk("R1 per", per_clk_en, 0);
    chk("R1 osc", osc_en, 1); chk("R1 irc", irc_out_en, 1);
    chk("R1 flash", flash_en, 1); chk("R1 pll", {pll_en, pll_conn, div_rst}, 0);
    chk("R1 code", exit_code, 0);
    rst = 1'b0;
    cyc();
    // R2 power-on warm-up
    ticks(LIM - 1);
    chk("R2 cpu before count", cpu_clk_en, 0);
    ticks(1);
    chk("R2 cpu one edge after count", cpu_clk_en, 0);
    cyc();
    chk("R2 cpu on", cpu_clk_en, 1); chk("R2 per on", per_clk_en, 1);
    // R9 PLL writes in run
    cfg_wr = 1; cfg_pll_en = 0; cfg_pll_conn = 1; cyc();
    chk("R9 conn needs en", {pll_en, pll_conn}, 2'b00);
    cfg_pll_en = 1; cyc(); cfg_wr = 0;
    chk("R9 pll on", {pll_en, pll_conn}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      req_idle  = VEC[i][6];
      req_sleep = VEC[i][5];
      irq_any   = VEC[i][4];
      wake_irq  = {{(NW-1){1'b0}}, VEC[i][3]};
      cyc();
      req_idle = 0; req_sleep = 0; irq_any = 0; wake_irq = '0;
      chk($sformatf("R3/R4/R5/R7/R8 vec%0d", i), {cpu_clk_en, per_clk_en, osc_en}, VEC[i][2:0]);
      if (i == 2) chk("R10 idle exit code", exit_code, 1);
      if (i == 3) begin
        chk("R6 pll cleared", {pll_en, pll_conn}, 2'b00);
        chk("R6 div_rst pulse", div_rst, 1);
        chk("R5 sleep gating", {irc_out_en, flash_en}, 2'b01);
      end
      if (i == 4) chk("R6 div_rst one cycle", div_rst, 0);
    end

    // R10 sleep exit code and clear on read
    chk("R10 sleep exit code", exit_code, 2);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R10 cleared", exit_code, 0);
    // R9 write ignored during warm-up
    cfg_wr = 1; cfg_pll_en = 1; cfg_pll_conn = 1; cyc(); cfg_wr = 0;
    chk("R9 ignored outside run", {pll_en, pll_conn}, 2'b00);
    // R7 count restarted from zero
    ticks(LIM - 1); cyc();
    chk("R7 count restarted", cpu_clk_en, 0);
    ticks(1); cyc();
    chk("R2 cpu after rewarm", cpu_clk_en, 1);
    chk("R9 pll still off after wake", {pll_en, pll_conn}, 2'b00);
    // R8 sleep request ignored while idle; R4 wake line ends idle
    req_idle = 1; cyc(); req_idle = 0;
    req_sleep = 1; cyc(); req_sleep = 0;
    chk("R8 sleep ignored in idle", {cpu_clk_en, osc_en}, 2'b01);
    wake_irq = 4'b0100; stat_rd = 1; cyc(); wake_irq = '0; stat_rd = 0;
    chk("R4 wake line ends idle", cpu_clk_en, 1);
    chk("R10 new exit beats read", exit_code, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule